// File: doc/BRIEF.md
# Gauge Controller Status Readout Port

This block is the serial slave port through which a host reads status from a two-channel pointer-gauge controller. Each 16-bit frame begins when chip select goes low. The unit then returns one of five status pages: device flags, the return-to-zero accumulator, the position of gauge 0, the position of gauge 1, or the combined velocity of both gauges. The page is chosen by a four-bit selector. This selector is written by the last valid configuration command and stays in force for every frame that follows. If a frame runs past 16 clocks, the output replays the bits that came in, delayed by 16 positions. This lets several units be chained and lets the host confirm what it sent.

The serial pins are synchronised into the system clock domain and oversampled. The serial clock idles low. The unit changes data on the falling edge and samples on the rising edge. The device-status page is built from flag inputs supplied by the rest of the controller. Supply faults are held until the end of the next transfer. An overvoltage also latches a driver-disable output, and only a configuration command can clear it.

Top module: `gauge_status_spi`

## Requirements
- R1: After synchronous reset, `spi_miso_oe` and `drv_disable` are 0 and the selector is 0000, so the first frame returns device status.
- R2: The device-status page, from bit 15 down to bit 0, is: dir[1], dir[0], zero_cw[1], zero_cw[0], off_target[1], off_target[0], held overvoltage, held undervoltage, cal_bad, (held overvoltage OR held undervoltage), moving[1], moving[0], homing[1], homing[0], hot[1], hot[0]. It is shifted out MSB first.
- R3: The selector holds its value across any number of read frames. Only a valid configuration command or reset changes it.
- R4: A valid configuration command is a frame of exactly 16 bits whose bits 15:12 equal 1110 (`CFG_OP`). Its bits 11:8 become the selector. Selector 1000 returns `rtz_word`, 1001 returns `pos0_word`, 1010 returns `pos1_word` and 1011 returns `vel_word`. Any value with bit 11 at 0, and any of 1100 to 1111, returns device status.
- R5: A frame with a bit count other than 16, or a 16-bit frame with any other value in bits 15:12, leaves the selector and `drv_disable` unchanged.
- R6: Once 16 bits have gone out, `spi_miso` carries the bits received since chip select fell, in the order they arrived.
- R7: A high level on `ov_raw` or `uv_raw` at any time since the previous frame ended sets the matching held flag for the next frame. A flag clears when chip select rises unless its raw input is still high.
- R8: `drv_disable` rises the cycle after `ov_raw` is high and stays high after `ov_raw` falls. It is cleared only by a valid configuration command with bit 0 = 1, and only while `ov_raw` is low.
- R9: `spi_miso_oe` is 1 while chip select is low and 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| dir | input | 2 | Per-gauge direction, 1 = moving away from position 0 |
| zero_cw | input | 2 | Per-gauge zero side, 1 = farthest clockwise |
| off_target | input | 2 | Per-gauge, 1 = not at the last commanded position |
| cal_bad | input | 1 | Clock calibration out of range |
| moving | input | 2 | Per-gauge pointer in motion |
| homing | input | 2 | Per-gauge return-to-zero in progress |
| hot | input | 2 | Per-gauge over-temperature |
| ov_raw | input | 1 | Live overvoltage comparator |
| uv_raw | input | 1 | Live undervoltage comparator |
| rtz_word | input | 16 | Return-to-zero accumulator page |
| pos0_word | input | 16 | Gauge 0 position page |
| pos1_word | input | 16 | Gauge 1 position page |
| vel_word | input | 16 | Combined velocity page |
| drv_disable | output | 1 | Latched disable for both gauge drivers |

## Verification
The case that is hardest to reach from the ports is a malformed configuration frame, one with the right opcode but 15 or 17 clocks. Such a frame must leave no trace, and the effect can only be seen one frame later in what the next read returns. The bench first selects a page whose content differs from every other page. It then sends short and long configuration frames that name another page, and reads back to show the original page is still selected. Held supply flags are reached the same way: the bench pulses the comparator input between frames and then reads two frames in a row.

// File: rtl/gss_pkg.sv
package gss_pkg;

  typedef struct packed {
    logic [1:0] dir;
    logic [1:0] zero_cw;
    logic [1:0] off_target;
    logic       cal_bad;
    logic [1:0] moving;
    logic [1:0] homing;
    logic [1:0] hot;
  } gauge_flags_t;

  typedef enum logic [1:0] {
    PG_RTZ  = 2'd0,
    PG_POS0 = 2'd1,
    PG_POS1 = 2'd2,
    PG_VEL  = 2'd3
  } page_t;

  function automatic logic [15:0] pack_device(input gauge_flags_t f,
                                              input logic ov, input logic uv);
    return {f.dir[1], f.dir[0], f.zero_cw[1], f.zero_cw[0],
            f.off_target[1], f.off_target[0], ov, uv, f.cal_bad, ov | uv,
            f.moving[1], f.moving[0], f.homing[1], f.homing[0],
            f.hot[1], f.hot[0]};
  endfunction

endpackage

// File: rtl/gss_sync.sv
module gss_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RST_VAL;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= RST_VAL;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gss_shifter.sv
module gss_shifter #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  csn_s,
  input  logic                  sck_s,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic                  miso,
  output logic                  miso_oe,
  output logic                  cs_rise,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int MSB     = FRAME_BITS - 1;

  logic                  csn_d, sck_d;
  logic                  cs_fall, sck_rise, sck_fall;
  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      cnt;
  logic                  miso_q, oe_q;

  assign cs_fall  = csn_d & ~csn_s;
  assign cs_rise  = ~csn_d & csn_s;
  assign sck_rise = ~sck_d & sck_s & ~csn_s;
  assign sck_fall = sck_d & ~sck_s & ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d  <= 1'b1;
      sck_d  <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      csn_d <= csn_s;
      sck_d <= sck_s;
      oe_q  <= ~csn_s;
      if (cs_fall) begin
        sh     <= load_word;
        miso_q <= load_word[MSB];
        cnt    <= '0;
      end else begin
        if (sck_rise) begin
          sh <= {sh[MSB-1:0], mosi_s};
          if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
        if (sck_fall) miso_q <= sh[MSB];
      end
    end
  end

  assign frame_ok   = cs_rise && (cnt == CNT_W'(FRAME_BITS));
  assign frame_word = sh;
  assign miso       = miso_q;
  assign miso_oe    = oe_q;

  assert_load_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (miso == $past(load_word[MSB])));

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CNT_MAX));

  assert_oe_follows_cs_R9: assert property (@(posedge clk) disable iff (rst)
    (csn_d && csn_s) |=> !miso_oe);
endmodule

// File: rtl/gss_status.sv
module gss_status
  import gss_pkg::*;
#(
  parameter int         WORD_W  = 16,
  parameter int         SEL_LSB = 8,
  parameter int         SEL_W   = 4,
  parameter logic [3:0] CFG_OP  = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  gauge_flags_t      flags,
  input  logic              ov_raw,
  input  logic              uv_raw,
  input  logic [WORD_W-1:0] rtz_word,
  input  logic [WORD_W-1:0] pos0_word,
  input  logic [WORD_W-1:0] pos1_word,
  input  logic [WORD_W-1:0] vel_word,
  input  logic              cs_rise,
  input  logic              frame_ok,
  input  logic [WORD_W-1:0] frame_word,
  output logic [WORD_W-1:0] status_word,
  output logic              drv_disable
);
  localparam int OP_LSB = WORD_W - 4;

  logic [SEL_W-1:0]  sel;
  logic              ov_hold, uv_hold, drv_q;
  logic              cfg_hit;
  logic [WORD_W-1:0] pages [4];
  page_t             pg;

  assign cfg_hit = frame_ok && (frame_word[WORD_W-1:OP_LSB] == CFG_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      ov_hold <= 1'b0;
      uv_hold <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      ov_hold <= ov_raw | (ov_hold & ~cs_rise);
      uv_hold <= uv_raw | (uv_hold & ~cs_rise);
      if (cfg_hit) sel <= frame_word[SEL_LSB +: SEL_W];
      if (ov_raw)                       drv_q <= 1'b1;
      else if (cfg_hit && frame_word[0]) drv_q <= 1'b0;
    end
  end

  assign pages[PG_RTZ]  = rtz_word;
  assign pages[PG_POS0] = pos0_word;
  assign pages[PG_POS1] = pos1_word;
  assign pages[PG_VEL]  = vel_word;
  assign pg = page_t'(sel[1:0]);

  always_comb begin
    if (sel[SEL_W-1] && (sel[SEL_W-2] == 1'b0)) status_word = pages[pg];
    else status_word = pack_device(flags, ov_hold, uv_hold);
  end

  assign drv_disable = drv_q;

  assert_sel_persists_R3: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> $stable(sel));

  assert_ov_held_R7: assert property (@(posedge clk) disable iff (rst)
    (ov_hold && !cs_rise) |=> ov_hold);

  assert_ov_disables_R8: assert property (@(posedge clk) disable iff (rst)
    ov_raw |=> drv_disable);

  assert_disable_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (drv_disable && !frame_ok) |=> drv_disable);
endmodule

// File: rtl/gauge_status_spi.sv
module gauge_status_spi
  import gss_pkg::*;
#(
  parameter int         FRAME_BITS  = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CFG_OP      = 4'hE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_csn,
  input  logic                  spi_sck,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  input  logic [1:0]            dir,
  input  logic [1:0]            zero_cw,
  input  logic [1:0]            off_target,
  input  logic                  cal_bad,
  input  logic [1:0]            moving,
  input  logic [1:0]            homing,
  input  logic [1:0]            hot,
  input  logic                  ov_raw,
  input  logic                  uv_raw,
  input  logic [FRAME_BITS-1:0] rtz_word,
  input  logic [FRAME_BITS-1:0] pos0_word,
  input  logic [FRAME_BITS-1:0] pos1_word,
  input  logic [FRAME_BITS-1:0] vel_word,
  output logic                  drv_disable
);
  logic [2:0]            pins_s;
  logic                  cs_rise, frame_ok;
  logic [FRAME_BITS-1:0] frame_word, status_word;
  gauge_flags_t          flags;

  assign flags = '{dir: dir, zero_cw: zero_cw, off_target: off_target,
                   cal_bad: cal_bad, moving: moving, homing: homing, hot: hot};

  gss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_csn, spi_sck, spi_mosi}),
    .q   (pins_s)
  );

  gss_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .csn_s      (pins_s[2]),
    .sck_s      (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .load_word  (status_word),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe),
    .cs_rise    (cs_rise),
    .frame_ok   (frame_ok),
    .frame_word (frame_word)
  );

  gss_status #(.WORD_W(FRAME_BITS), .CFG_OP(CFG_OP)) u_status (
    .clk         (clk),
    .rst         (rst),
    .flags       (flags),
    .ov_raw      (ov_raw),
    .uv_raw      (uv_raw),
    .rtz_word    (rtz_word),
    .pos0_word   (pos0_word),
    .pos1_word   (pos1_word),
    .vel_word    (vel_word),
    .cs_rise     (cs_rise),
    .frame_ok    (frame_ok),
    .frame_word  (frame_word),
    .status_word (status_word),
    .drv_disable (drv_disable)
  );
endmodule

// File: tb/gauge_status_spi_tb.sv
module gauge_status_spi_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, drv_disable;
  logic [1:0] dir = '0, zero_cw = '0, off_target = '0, moving = '0, homing = '0, hot = '0;
  logic cal_bad = 1'b0, ov_raw = 1'b0, uv_raw = 1'b0;
  logic [15:0] rtz_word = 16'h1A2B, pos0_word = 16'h3C4D, pos1_word = 16'h5E6F, vel_word = 16'h7081;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gauge_status_spi u_dut (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .dir(dir), .zero_cw(zero_cw),
    .off_target(off_target), .cal_bad(cal_bad), .moving(moving), .homing(homing),
    .hot(hot), .ov_raw(ov_raw), .uv_raw(uv_raw), .rtz_word(rtz_word),
    .pos0_word(pos0_word), .pos1_word(pos1_word), .vel_word(vel_word),
    .drv_disable(drv_disable));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_exp(input logic ov, input logic uv);
    return {dir[1], dir[0], zero_cw[1], zero_cw[0], off_target[1], off_target[0],
            ov, uv, cal_bad, ov | uv, moving[1], moving[0], homing[1], homing[0],
            hot[1], hot[0]};
  endfunction

  function automatic logic [31:0] cfg(input logic [3:0] sel, input logic en);
    return {16'h0, 4'hE, sel, 7'h0, en};
  endfunction

  task automatic xfer(input logic [31:0] tx, input int nbits,
                      output logic [31:0] rx, output logic oe_seen);
    rx = '0;
    @(negedge clk) spi_csn = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[nbits-1-i];
      repeat (HALF) @(negedge clk);
      if (i == 0) oe_seen = spi_miso_oe;
      rx = {rx[30:0], spi_miso};
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic read16(output logic [15:0] w);
    logic [31:0] r;
    logic oe;
    xfer(32'h0, 16, r, oe);
    w = r[15:0];
  endtask

  task automatic write16(input logic [31:0] tx);
    logic [31:0] r;
    logic oe;
    xfer(tx, 16, r, oe);
  endtask

  task automatic t_reset;
    logic [15:0] w;
    check("R1 oe after reset", 32'(spi_miso_oe), 32'h0);
    check("R1 drv_disable after reset", 32'(drv_disable), 32'h0);
    read16(w);
    check("R1 first page is device", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
  endtask

  task automatic t_device;
    logic [15:0] w;
    dir = 2'b10; zero_cw = 2'b01; off_target = 2'b10; cal_bad = 1'b1;
    moving = 2'b01; homing = 2'b10; hot = 2'b01;
    read16(w);
    check("R2 device pattern A", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
    dir = 2'b01; zero_cw = 2'b10; off_target = 2'b01; cal_bad = 1'b0;
    moving = 2'b10; homing = 2'b01; hot = 2'b10;
    read16(w);
    check("R2 device pattern B", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
  endtask

  task automatic t_select;
    logic [15:0] w;
    write16(cfg(4'b1001, 1'b0));
    read16(w);
    check("R4 sel 1001 pos0", 32'(w), 32'(pos0_word));
    read16(w);
    check("R3 sel persists", 32'(w), 32'(pos0_word));
    write16(cfg(4'b1000, 1'b0)); read16(w);
    check("R4 sel 1000 rtz", 32'(w), 32'(rtz_word));
    write16(cfg(4'b1010, 1'b0)); read16(w);
    check("R4 sel 1010 pos1", 32'(w), 32'(pos1_word));
    write16(cfg(4'b1011, 1'b0)); read16(w);
    check("R4 sel 1011 vel", 32'(w), 32'(vel_word));
    write16(cfg(4'b1101, 1'b0)); read16(w);
    check("R4 sel 1101 device", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
    write16(cfg(4'b0011, 1'b0)); read16(w);
    check("R4 sel 0011 device", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
  endtask

  task automatic t_badframes;
    logic [15:0] w;
    logic [31:0] r;
    logic oe;
    write16(cfg(4'b1010, 1'b0));
    xfer({17'h0, 4'hE, 4'b1001, 7'h0}, 15, r, oe);
    read16(w);
    check("R5 15-bit frame ignored", 32'(w), 32'(pos1_word));
    xfer({15'h0, 4'hE, 4'b1001, 7'h0, 2'b00}, 17, r, oe);
    read16(w);
    check("R5 17-bit frame ignored", 32'(w), 32'(pos1_word));
    write16({16'h0, 4'h3, 4'b1001, 8'h0});
    read16(w);
    check("R5 wrong opcode ignored", 32'(w), 32'(pos1_word));
  endtask

  task automatic t_echo;
    logic [31:0] r;
    logic oe;
    write16(cfg(4'b1011, 1'b0));
    xfer(32'hC3A5_0F0F, 32, r, oe);
    check("R6 status then echo", r, {vel_word, 16'hC3A5});
    check("R9 oe during frame", 32'(oe), 32'h1);
    check("R9 oe idle after frame", 32'(spi_miso_oe), 32'h0);
  endtask

  task automatic t_voltage;
    logic [15:0] w;
    write16(cfg(4'b0000, 1'b1));
    @(negedge clk) uv_raw = 1'b1;
    repeat (3) @(negedge clk);
    uv_raw = 1'b0;
    repeat (3) @(negedge clk);
    read16(w);
    check("R7 uv pulse held", 32'(w), 32'(dev_exp(1'b0, 1'b1)));
    read16(w);
    check("R7 uv cleared next frame", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
    @(negedge clk) ov_raw = 1'b1;
    repeat (3) @(negedge clk);
    read16(w);
    check("R7 ov live frame 1", 32'(w), 32'(dev_exp(1'b1, 1'b0)));
    read16(w);
    check("R7 ov live frame 2", 32'(w), 32'(dev_exp(1'b1, 1'b0)));
    @(negedge clk) ov_raw = 1'b0;
    repeat (3) @(negedge clk);
    read16(w);
    check("R7 ov still held after drop", 32'(w), 32'(dev_exp(1'b1, 1'b0)));
    read16(w);
    check("R7 ov cleared", 32'(w), 32'(dev_exp(1'b0, 1'b0)));
  endtask

  task automatic t_drive;
    write16(cfg(4'b0000, 1'b1));
    check("R8 enabled before fault", 32'(drv_disable), 32'h0);
    @(negedge clk) ov_raw = 1'b1;
    @(negedge clk);
    check("R8 disable on ov", 32'(drv_disable), 32'h1);
    write16(cfg(4'b0000, 1'b1));
    check("R8 enable ignored while ov", 32'(drv_disable), 32'h1);
    @(negedge clk) ov_raw = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 disable sticky", 32'(drv_disable), 32'h1);
    write16(cfg(4'b0000, 1'b0));
    check("R8 cfg without enable bit", 32'(drv_disable), 32'h1);
    write16({16'h0, 4'h3, 12'h001});
    check("R5 wrong opcode keeps disable", 32'(drv_disable), 32'h1);
    write16(cfg(4'b0000, 1'b1));
    check("R8 re-enable command", 32'(drv_disable), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_device();
    t_select();
    t_badframes();
    t_echo();
    t_voltage();
    t_drive();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule